// File: doc/BRIEF.md
# DDR SDRAM Power-Up Sequencer

This block owns the DDR SDRAM command bus from reset until the memory is ready for normal traffic. It waits for a `start` level that says supplies and clock are stable. It then keeps clock-enable low for a power-up hold-off, which is measured in clock cycles derived from a frequency parameter. After that it walks one fixed list of commands: a clock-enable-high NOP, precharge-all, extended mode-register load with the DLL enabled, mode-register load with DLL reset, a second precharge-all, two auto-refreshes, and a final mode-register load without DLL reset.

Between commands the bus carries NOP, and every gap obeys a parameterised cycle count: tRP, tMRD or tRFC. A separate counter measures the DLL lock time from the DLL-reset load. `init_done` rises only after both the last tMRD gap and that lock count are over. It then stays high until reset, so a normal-operation controller can take over the bus.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` has been sampled low, or `start` has not yet been sampled high, `cke`=0, `init_done`=0, `ba`=0, `addr`=0 and {`cs_n`,`ras_n`,`cas_n`,`we_n`} = 0111 (NOP).
- R2: If `start` is first sampled high at edge s, `cke` stays 0 with NOP through cycle s+P, where P = CLK_MHZ*PWR_WAIT_US. In cycle s+P+1 the bus shows NOP with `cke`=1.
- R3: One cycle after the clock-enable NOP, precharge-all is issued: command 0010, `addr` bit 10 = 1, all other `addr` bits 0, `ba`=0.
- R4: T_RP cycles after the first precharge-all, an extended mode-register load is issued: command 0000, `ba`=01 (BA1=0, BA0=1), `addr` = EXT_MODE_VAL with bit 0 cleared (DLL enabled).
- R5: T_MRD cycles after the extended load, a mode-register load is issued with `ba`=00 and `addr` = MODE_VAL with bit 8 (DLL reset) set.
- R6: T_MRD cycles after the DLL-reset load, a second precharge-all (as in R3) is issued. T_RP cycles later comes auto-refresh (command 0001, `ba`=0, `addr`=0), and a second auto-refresh follows T_RFC cycles after the first.
- R7: T_RFC cycles after the second auto-refresh, a mode-register load is issued with `ba`=00 and `addr` = MODE_VAL with bit 8 cleared.
- R8: Every other cycle after the clock-enable NOP carries NOP (0111) with `cke`=1, `ba`=0 and `addr`=0. No command other than NOP is ever issued while `cke`=0.
- R9: `init_done` first rises in cycle max(f+T_MRD, m+DLL_LOCK_CYC+1)+1, where m and f are the cycles of the DLL-reset load and of the final load. It is therefore never high within DLL_LOCK_CYC cycles of the DLL-reset load.
- R10: Once high, `init_done` stays high and the bus stays NOP with `cke`=1 until reset.
- R11: `start` is ignored once it has been sampled high: dropping or toggling it changes neither the command sequence nor its timing.
- R12: `rst_n` sampled low at any point of the sequence returns the block to the R1 state on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Supplies and clock are stable; begins the sequence |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/mode address bus |
| init_done | output | 1 | Sticky flag: memory initialised, bus may be handed over |

## Verification
The gap checks assume the timing parameters are at least 2, so that every gap contains at least one NOP. They also assume `start` is a level that is only meaningful while the block waits for it. The DLL-lock check takes for granted that reset is not released in the middle of a cycle.

The bench holds the timing parameters at legal values. It drives `start` only at the falling edge. It either leaves `start` high, or, once the first rising sample has been taken, toggles it at random to exercise R11. Random mid-sequence resets, random idle lengths and random start delays vary where in the list each reset and each start lands.

// File: rtl/ddr_init_pkg.sv
// Package: shared encodings for the DDR power-up sequencer.
// Assumes a four-wire command bus ordered {cs_n, ras_n, cas_n, we_n}.
package ddr_init_pkg;

    // Command codes on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    // Sequencer states; command states last one cycle, GAP states hold NOP
    typedef enum logic [4:0] {
        ST_HOLD      = 5'd0,
        ST_PWR_WAIT  = 5'd1,
        ST_CKE_NOP   = 5'd2,
        ST_PRE_A     = 5'd3,
        ST_GAP_RP_A  = 5'd4,
        ST_EMR       = 5'd5,
        ST_GAP_MRD_A = 5'd6,
        ST_MR_DLLRST = 5'd7,
        ST_GAP_MRD_B = 5'd8,
        ST_PRE_B     = 5'd9,
        ST_GAP_RP_B  = 5'd10,
        ST_REF_A     = 5'd11,
        ST_GAP_RFC_A = 5'd12,
        ST_REF_B     = 5'd13,
        ST_GAP_RFC_B = 5'd14,
        ST_MR_RUN    = 5'd15,
        ST_GAP_MRD_C = 5'd16,
        ST_LOCK_WAIT = 5'd17,
        ST_READY     = 5'd18
    } seq_state_e;

    // Address bit that selects all banks on a precharge
    localparam int ALL_BANK_BIT = 10;

    // Larger of two integers, for counter sizing
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_init_timer.sv
// Module: ddr_init_timer
// Down-counter that measures every wait of the sequence (power-up hold-off
// and the tRP / tMRD / tRFC gaps). A load sets the remaining count; the
// counter then decrements to zero and holds there.
// Assumes loads only arrive once the previous wait has run out.
module ddr_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_zero
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: load, else decrement towards zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt_zero = (cnt_q == '0);

    // R8: a new wait never cuts an unfinished one short
    // R8
    load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> cnt_zero);

    // R8: the count only moves downwards unless reloaded
    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_zero) |=> cnt_zero);

endmodule

// File: rtl/ddr_init_dll_cnt.sv
// Module: ddr_init_dll_cnt
// Measures the DLL lock time that must pass after the DLL-reset mode load.
// lock_ok is high once LOCK_CYC cycles have passed after the arm cycle, and
// it stays high until reset.
// Assumes arm is pulsed exactly once per sequence.
module ddr_init_dll_cnt #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic lock_ok
);

    localparam int LCK_W = $clog2(LOCK_CYC + 1);

    logic [LCK_W-1:0] left_q;
    logic             armed_q;

    // Arm flag: marks that the DLL-reset load has been issued
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else if (arm) armed_q <= 1'b1;
    end

    // Remaining lock cycles, saturating at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (arm) begin
            left_q <= LCK_W'(LOCK_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - LCK_W'(1);
        end
    end

    assign lock_ok = armed_q && (left_q == '0);

    // R9: once reached, the lock condition holds until reset
    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_ok && !arm) |=> lock_ok);

    // R9: the cycle after arming, the lock is never ok
    // R9
    arm_not_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !lock_ok);

endmodule

// File: rtl/ddr_init_cmd_enc.sv
// Module: ddr_init_cmd_enc
// Maps the sequencer state onto the DDR command pins. Purely combinational
// (Moore): every pin is a function of the state register only, so the bus
// changes once per clock and no input reaches it directly.
// Assumes ADDR_W covers bit 10 and both mode-word control bits.
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
#(
    parameter int              ADDR_W       = 13,
    parameter int              BA_W         = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL     = 13'h0062,
    parameter logic [ADDR_W-1:0] EXT_MODE_VAL = 13'h0000,
    parameter int              DLL_RST_BIT  = 8,
    parameter int              DLL_DIS_BIT  = 0
) (
    input  seq_state_e        state,
    output logic              cke,
    output ddr_cmd_e          cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] RST_MASK   = ADDR_W'(1) << DLL_RST_BIT;
    localparam logic [ADDR_W-1:0] DIS_MASK   = ADDR_W'(1) << DLL_DIS_BIT;
    localparam logic [ADDR_W-1:0] WORD_EMR   = EXT_MODE_VAL & ~DIS_MASK;
    localparam logic [ADDR_W-1:0] WORD_DLLR  = MODE_VAL | RST_MASK;
    localparam logic [ADDR_W-1:0] WORD_RUN   = MODE_VAL & ~RST_MASK;
    localparam logic [ADDR_W-1:0] WORD_PALL  = ADDR_W'(1) << ALL_BANK_BIT;
    localparam logic [BA_W-1:0]   BANK_EMR   = BA_W'(1);

    // Clock enable: low only during the two power-up states
    always_comb begin
        cke = !((state == ST_HOLD) || (state == ST_PWR_WAIT));
    end

    // Command, bank and address decode per state
    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        unique case (state)
            ST_PRE_A, ST_PRE_B: begin
                cmd  = CMD_PRE;
                addr = WORD_PALL;
            end
            ST_EMR: begin
                cmd  = CMD_LMR;
                ba   = BANK_EMR;
                addr = WORD_EMR;
            end
            ST_MR_DLLRST: begin
                cmd  = CMD_LMR;
                addr = WORD_DLLR;
            end
            ST_REF_A, ST_REF_B: begin
                cmd  = CMD_REF;
            end
            ST_MR_RUN: begin
                cmd  = CMD_LMR;
                addr = WORD_RUN;
            end
            default: begin
                cmd  = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/ddr_init_seq.sv
// Module: ddr_init_seq (top)
// Drives the DDR power-up sequence: CKE-low hold-off, CKE-high NOP,
// precharge-all, extended mode load (DLL on), mode load with DLL reset,
// precharge-all, two auto-refreshes, and a final mode load. Each gap is
// timed in cycles. init_done is raised once the last tMRD gap and the DLL
// lock count are both over, and it is held until reset.
// Assumes T_RP, T_MRD, T_RFC >= 2 and start is a stable level.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int              CLK_MHZ      = 200,
    parameter int              PWR_WAIT_US  = 200,
    parameter int              T_RP         = 3,
    parameter int              T_MRD        = 2,
    parameter int              T_RFC        = 15,
    parameter int              DLL_LOCK_CYC = 200,
    parameter int              ADDR_W       = 13,
    parameter int              BA_W         = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL     = 13'h0062,
    parameter logic [ADDR_W-1:0] EXT_MODE_VAL = 13'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int PWR_CYC = CLK_MHZ * PWR_WAIT_US;
    localparam int MAX_WAIT = imax(imax(PWR_CYC, T_RP), imax(T_MRD, T_RFC));
    localparam int CNT_W = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] LD_PWR = CNT_W'(PWR_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 2);
    localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 2);
    localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 2);

    seq_state_e       state_q;
    seq_state_e       state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             dll_arm;
    logic             dll_ok;
    ddr_cmd_e         cmd;

    // Wait timer shared by all gaps
    ddr_init_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt_zero (tmr_zero)
    );

    // DLL lock counter started by the DLL-reset load
    ddr_init_dll_cnt #(
        .LOCK_CYC (DLL_LOCK_CYC)
    ) u_dll (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (dll_arm),
        .lock_ok (dll_ok)
    );

    // Command pin decode
    ddr_init_cmd_enc #(
        .ADDR_W       (ADDR_W),
        .BA_W         (BA_W),
        .MODE_VAL     (MODE_VAL),
        .EXT_MODE_VAL (EXT_MODE_VAL),
        .DLL_RST_BIT  (8),
        .DLL_DIS_BIT  (0)
    ) u_enc (
        .state (state_q),
        .cke   (cke),
        .cmd   (cmd),
        .ba    (ba),
        .addr  (addr)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign init_done = (state_q == ST_READY);
    assign dll_arm   = (state_q == ST_MR_DLLRST);

    // Timer load: on start acceptance and on every timed command
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_HOLD: begin
                tmr_load = start;
                tmr_val  = LD_PWR;
            end
            ST_PRE_A, ST_PRE_B: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RP;
            end
            ST_EMR, ST_MR_DLLRST, ST_MR_RUN: begin
                tmr_load = 1'b1;
                tmr_val  = LD_MRD;
            end
            ST_REF_A, ST_REF_B: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RFC;
            end
            default: begin
                tmr_load = 1'b0;
            end
        endcase
    end

    // Next-state logic: fixed command list, gaps leave when the timer ends
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:      if (start) state_d = ST_PWR_WAIT;
            ST_PWR_WAIT:  if (tmr_zero) state_d = ST_CKE_NOP;
            ST_CKE_NOP:   state_d = ST_PRE_A;
            ST_PRE_A:     state_d = ST_GAP_RP_A;
            ST_GAP_RP_A:  if (tmr_zero) state_d = ST_EMR;
            ST_EMR:       state_d = ST_GAP_MRD_A;
            ST_GAP_MRD_A: if (tmr_zero) state_d = ST_MR_DLLRST;
            ST_MR_DLLRST: state_d = ST_GAP_MRD_B;
            ST_GAP_MRD_B: if (tmr_zero) state_d = ST_PRE_B;
            ST_PRE_B:     state_d = ST_GAP_RP_B;
            ST_GAP_RP_B:  if (tmr_zero) state_d = ST_REF_A;
            ST_REF_A:     state_d = ST_GAP_RFC_A;
            ST_GAP_RFC_A: if (tmr_zero) state_d = ST_REF_B;
            ST_REF_B:     state_d = ST_GAP_RFC_B;
            ST_GAP_RFC_B: if (tmr_zero) state_d = ST_MR_RUN;
            ST_MR_RUN:    state_d = ST_GAP_MRD_C;
            ST_GAP_MRD_C: if (tmr_zero) state_d = ST_LOCK_WAIT;
            ST_LOCK_WAIT: if (dll_ok) state_d = ST_READY;
            ST_READY:     state_d = ST_READY;
            default:      state_d = ST_HOLD;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // R1 / R12: the edge after reset shows the power-up idle bus
    // R12
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!cke && !init_done && (cmd == CMD_NOP)));

    // R8: no executable command while clock enable is low
    // R8
    cke_low_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd == CMD_NOP));

    // R9: init_done never rises before the DLL lock count has expired
    // R9
    done_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> dll_ok);

    // R10: init_done is sticky
    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R10: after completion only NOP with clock enable high
    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cke && (cmd == CMD_NOP)));

endmodule

// File: tb/ddr_init_seq_bench.sv
// Bench: random start delays, start toggling and mid-sequence resets,
// checked cycle by cycle against a schedule computed from the requirements.
module ddr_init_seq_bench;

    localparam int CLK_MHZ = 200;
    localparam int PWR_US  = 1;
    localparam int TRP     = 3;
    localparam int TMRD    = 2;
    localparam int TRFC    = 15;
    localparam int DLLC    = 200;
    localparam int AW      = 13;
    localparam int BW      = 2;
    localparam logic [AW-1:0] MODEV = 13'h0162;
    localparam logic [AW-1:0] EXTV  = 13'h0003;

    localparam int P   = CLK_MHZ * PWR_US;
    localparam int KP1 = P + 2;
    localparam int KE  = KP1 + TRP;
    localparam int KM  = KE + TMRD;
    localparam int KP2 = KM + TMRD;
    localparam int KR1 = KP2 + TRP;
    localparam int KR2 = KR1 + TRFC;
    localparam int KF  = KR2 + TRFC;
    localparam int KD  = ((KF + TMRD) > (KM + DLLC + 1) ? (KF + TMRD) : (KM + DLLC + 1)) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    ddr_init_seq #(
        .CLK_MHZ (CLK_MHZ), .PWR_WAIT_US (PWR_US), .T_RP (TRP), .T_MRD (TMRD),
        .T_RFC (TRFC), .DLL_LOCK_CYC (DLLC), .ADDR_W (AW), .BA_W (BW),
        .MODE_VAL (MODEV), .EXT_MODE_VAL (EXTV)
    ) u_ddr_init_seq (
        .clk (clk), .rst_n (rst_n), .start (start), .cke (cke), .cs_n (cs_n),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr),
        .init_done (init_done)
    );

    // Packed view {done, cke, cmd[3:0], ba, addr}
    typedef logic [1+1+4+BW+AW-1:0] bus_t;

    function automatic bus_t pack(input logic d, input logic k, input logic [3:0] c,
                                  input logic [BW-1:0] b, input logic [AW-1:0] a);
        return {d, k, c, b, a};
    endfunction

    // Expected bus k cycles after the start-sampling edge (k<=0: idle)
    function automatic bus_t expect_at(input int k);
        logic d = (k >= KD);
        if (k <= P)   return pack(1'b0, 1'b0, 4'b0111, '0, '0);
        if (k == KP1 || k == KP2) return pack(d, 1'b1, 4'b0010, '0, AW'(1) << 10);
        if (k == KE)  return pack(d, 1'b1, 4'b0000, BW'(1), EXTV & ~AW'(1));
        if (k == KM)  return pack(d, 1'b1, 4'b0000, '0, MODEV | (AW'(1) << 8));
        if (k == KR1 || k == KR2) return pack(d, 1'b1, 4'b0001, '0, '0);
        if (k == KF)  return pack(d, 1'b1, 4'b0000, '0, MODEV & ~(AW'(1) << 8));
        return pack(d, 1'b1, 4'b0111, '0, '0);
    endfunction

    // Requirement tag for the slot at offset k
    function automatic string tag_at(input int k);
        if (k <= 0)   return "R1";
        if (k <= P + 1) return "R2";
        if (k == KP1) return "R3";
        if (k == KE)  return "R4";
        if (k == KM)  return "R5";
        if (k == KP2 || k == KR1 || k == KR2) return "R6";
        if (k == KF)  return "R7";
        if (k == KD - 1 || k == KD) return "R9";
        if (k > KD)   return "R10";
        return "R8";
    endfunction

    function automatic bus_t actual();
        return pack(init_done, cke, {cs_n, ras_n, cas_n, we_n}, ba, addr);
    endfunction

    // One comparison of the whole bus
    task automatic check(input int k, input string tag);
        n_checks++;
        if (actual() !== expect_at(k)) begin
            n_fail++;
            $display("FAIL %s k=%0d actual=%h expected=%h", tag, k, actual(), expect_at(k));
        end
    endtask

    // Synchronous reset for len cycles, then check the idle state
    task automatic do_reset(input int len);
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            check(0, "R12");
        end
        rst_n = 1'b1;
    endtask

    // One run: idle, start, then follow the schedule to abort_k or end
    task automatic run(input int idle, input bit toggle, input int abort_k);
        for (int i = 0; i < idle; i++) begin
            @(negedge clk);
            check(0, "R1");
        end
        start = 1'b1;
        for (int k = 1; k <= KD + 12; k++) begin
            @(negedge clk);
            if (abort_k != 0 && k == abort_k) begin
                rst_n = 1'b0;
                @(negedge clk);
                check(0, "R12");
                rst_n = 1'b1;
                start = 1'b0;
                return;
            end
            check(k, toggle ? {tag_at(k), "/R11"} : tag_at(k));
            if (toggle) start = 1'($urandom_range(0, 1));
        end
        start = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d cycles expected<150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(3);
        // Directed: immediate start, start held (R2..R10)
        run(0, 1'b0, 0);
        do_reset(1);
        // Directed: start toggling after acceptance (R11)
        run(5, 1'b1, 0);
        // Directed: reset in the middle of each wait kind (R12)
        do_reset(2);
        run(1, 1'b0, P / 2);
        do_reset(1);
        run(2, 1'b0, KM + 1);
        do_reset(1);
        run(0, 1'b0, KR2 + 3);
        // Random mix
        for (int t = 0; t < 6; t++) begin
            do_reset(int'($urandom_range(1, 4)));
            run(int'($urandom_range(0, 20)), 1'($urandom_range(0, 1)),
                ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, KD + 5)) : 0);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule